// File: doc/BRIEF.md
# Power-Sourcing Port Sequencer

This block steers one power-sourcing Ethernet port from an unpowered state to a powered one. It does not measure anything itself. A front end outside the block runs the probes: the sequencer raises a request line, and the front end answers with a one-cycle done strobe and a 3-bit result code. The sequencer waits a programmable gap between detection probes and repeats detection until a valid signature appears. It then runs one classification event, or two events with a mark phase after each. Depending on the mode, it applies power by itself or waits for a host command.

There are four operating modes. In shutdown the port is held unpowered. In manual the port is powered or unpowered only by host command, with no probing. Semi-auto probes and classifies, then waits for a host power-on command. Auto runs the whole sequence by itself, and only auto escalates to two-event classification for high-power devices.

Host commands are single bytes tagged with this port's number. A fault input (overcurrent or disconnect) drops power on a powered port and leaves a sticky fault flag. A registered current readback returns zero whenever the port is unpowered.

Top module: `pse_port_seq`

## Requirements
- R1: After reset the port is unpowered, both status codes read 000, the fault flag is clear and no probe request is raised.
- R2: Mode code 00 (shutdown) raises no probe request, and a power-on command has no effect on `port_on`.
- R3: In auto or semi-auto, every detection result is copied to `det_status`. Any code other than 100 (valid signature) sends the port back to wait exactly `DET_GAP` cycles with no request raised before the next probe. Codes 001 short, 011 low, 101 high and 110 open are all treated this way, as are 000 and the reserved codes.
- R4: In auto (mode 11) with `plus_en` low, a detection result of 100 is followed by a single classification event, and power is applied on its done strobe. The class code is shown on `cls_status`, with 001..011 meaning Class 1..3 and 100 meaning Class 4.
- R5: In auto with `plus_en` high, a first class result of 100 starts a mark phase, a second classification event and a second mark phase, in that order. Any other first result powers the port at once with no mark phase.
- R6: After the two-event sequence, power is applied only if the second result is 100. Otherwise the port stays unpowered, `cls_status` shows the second result, and detection restarts after `DET_GAP` cycles.
- R7: In semi-auto (mode 10) only one classification event runs, even with `plus_en` high. The port then waits unpowered until the command byte 0x04 OR'd with `PORT_ID` arrives. A byte with another port number is ignored.
- R8: In manual (mode 01) no probe request is raised, and the power-on byte powers the port directly. In any mode the byte 0x08 OR'd with `PORT_ID` removes power from a powered port.
- R9: A fault while powered removes power on the next edge and sets `fault_evt`, which stays set until reset. In auto or semi-auto, detection restarts after `DET_GAP` cycles.
- R10: `cur_rd` follows `cur_in` one cycle after the port is powered, and reads zero while the port is unpowered.
- R11: Switching to shutdown removes power on the next edge and clears both status codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | 00 shutdown, 01 manual, 10 semi-auto, 11 auto |
| plus_en | input | 1 | High-power (two-event) classification enable |
| det_done | input | 1 | Detection result strobe |
| det_code | input | 3 | Detection result code |
| cls_done | input | 1 | Classification result strobe |
| cls_code | input | 3 | Classification result code |
| mark_done | input | 1 | End of mark phase strobe |
| cmd_valid | input | 1 | Host command byte valid |
| cmd_byte | input | 8 | Host command byte |
| fault | input | 1 | Overcurrent or disconnect fault |
| cur_in | input | CUR_W | Digitized port current |
| det_req | output | 1 | Detection probe request |
| cls_req | output | 1 | Classification event request |
| mark_req | output | 1 | Mark phase request |
| port_on | output | 1 | Port power applied |
| det_status | output | 3 | Last detection code |
| cls_status | output | 3 | Last class code |
| fault_evt | output | 1 | Sticky fault event |
| cur_rd | output | CUR_W | Current readback, zero when unpowered |

## Verification
Each strobe, command or fault that the bench drives takes effect at the next rising edge. `port_on`, the status codes and the request lines therefore settle one edge later, and `cur_rd` settles a second edge after `port_on`. The bench drives and samples on falling edges, so it reads each result half a cycle after the edge that produced it. Gap lengths are counted as the falling edges seen with no request raised, and the count must equal `DET_GAP` exactly. The bench sweeps every detection code and every first-event and second-event class code.

// File: rtl/pse_seq_pkg.sv
package pse_seq_pkg;
  localparam logic [1:0] MODE_SHUT = 2'b00;
  localparam logic [1:0] MODE_MAN  = 2'b01;
  localparam logic [1:0] MODE_SEMI = 2'b10;
  localparam logic [1:0] MODE_AUTO = 2'b11;

  localparam logic [2:0] DET_GOOD  = 3'b100;
  localparam logic [2:0] CLS_FOUR  = 3'b100;

  typedef enum logic [3:0] {
    ST_IDLE, ST_GAP, ST_DET, ST_CLS1, ST_MARK1,
    ST_CLS2, ST_MARK2, ST_HOLD, ST_ON
  } seq_state_e;
endpackage

// File: rtl/pse_cmd_decode.sv
module pse_cmd_decode #(
  parameter logic [1:0] PORT_ID = 2'd1
) (
  input  logic       cmd_valid,
  input  logic [7:0] cmd_byte,
  output logic       on_hit,
  output logic       off_hit
);
  localparam logic [7:0] ON_BYTE  = 8'h04 | {6'd0, PORT_ID};
  localparam logic [7:0] OFF_BYTE = 8'h08 | {6'd0, PORT_ID};

  assign on_hit  = cmd_valid && (cmd_byte == ON_BYTE);
  assign off_hit = cmd_valid && (cmd_byte == OFF_BYTE);
endmodule

// File: rtl/pse_gap_timer.sv
module pse_gap_timer #(
  parameter int GAP = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic done
);
  localparam int CW = (GAP > 1) ? $clog2(GAP + 1) : 1;
  localparam logic [CW-1:0] LAST = CW'(GAP - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign done = run && (cnt_q == LAST);
endmodule

// File: rtl/pse_cur_gate.sv
module pse_cur_gate #(
  parameter int CUR_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             on,
  input  logic [CUR_W-1:0] cur_in,
  output logic [CUR_W-1:0] cur_rd
);
  always_ff @(posedge clk) begin
    if (rst || !on) cur_rd <= '0;
    else            cur_rd <= cur_in;
  end
endmodule

// File: rtl/pse_port_seq.sv
module pse_port_seq
  import pse_seq_pkg::*;
#(
  parameter int         DET_GAP = 6,
  parameter int         CUR_W   = 10,
  parameter logic [1:0] PORT_ID = 2'd1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode,
  input  logic             plus_en,
  input  logic             det_done,
  input  logic [2:0]       det_code,
  input  logic             cls_done,
  input  logic [2:0]       cls_code,
  input  logic             mark_done,
  input  logic             cmd_valid,
  input  logic [7:0]       cmd_byte,
  input  logic             fault,
  input  logic [CUR_W-1:0] cur_in,
  output logic             det_req,
  output logic             cls_req,
  output logic             mark_req,
  output logic             port_on,
  output logic [2:0]       det_status,
  output logic [2:0]       cls_status,
  output logic             fault_evt,
  output logic [CUR_W-1:0] cur_rd
);
  seq_state_e st_q, st_d;
  logic on_hit, off_hit, gap_done;
  logic [2:0] det_q, cls_q;
  logic flt_q;

  pse_cmd_decode #(.PORT_ID(PORT_ID)) u_cmd (
    .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .on_hit(on_hit), .off_hit(off_hit)
  );

  pse_gap_timer #(.GAP(DET_GAP)) u_gap (
    .clk(clk), .rst(rst), .run(st_q == ST_GAP), .done(gap_done)
  );

  pse_cur_gate #(.CUR_W(CUR_W)) u_cur (
    .clk(clk), .rst(rst), .on(st_q == ST_ON), .cur_in(cur_in), .cur_rd(cur_rd)
  );

  always_comb begin
    st_d = st_q;
    if (mode == MODE_SHUT) begin
      st_d = ST_IDLE;
    end else begin
      case (st_q)
        ST_IDLE:  if (mode == MODE_MAN) begin
                    if (on_hit) st_d = ST_ON;
                  end else st_d = ST_GAP;
        ST_GAP:   if (gap_done) st_d = ST_DET;
        ST_DET:   if (det_done) st_d = (det_code == DET_GOOD) ? ST_CLS1 : ST_GAP;
        ST_CLS1:  if (cls_done) begin
                    if (mode == MODE_AUTO && plus_en && cls_code == CLS_FOUR) st_d = ST_MARK1;
                    else if (mode == MODE_AUTO) st_d = ST_ON;
                    else st_d = ST_HOLD;
                  end
        ST_MARK1: if (mark_done) st_d = ST_CLS2;
        ST_CLS2:  if (cls_done) st_d = ST_MARK2;
        ST_MARK2: if (mark_done) st_d = (cls_q == CLS_FOUR) ? ST_ON : ST_GAP;
        ST_HOLD:  if (on_hit) st_d = ST_ON;
                  else if (off_hit) st_d = ST_IDLE;
        ST_ON:    if (fault) st_d = (mode == MODE_MAN) ? ST_IDLE : ST_GAP;
                  else if (off_hit) st_d = ST_IDLE;
        default:  st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      det_q <= '0;
      cls_q <= '0;
      flt_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_ON && fault) flt_q <= 1'b1;
      if (mode == MODE_SHUT) begin
        det_q <= '0;
        cls_q <= '0;
      end else begin
        if (st_q == ST_DET && det_done) det_q <= det_code;
        if ((st_q == ST_CLS1 || st_q == ST_CLS2) && cls_done) cls_q <= cls_code;
      end
    end
  end

  assign det_req    = (st_q == ST_DET);
  assign cls_req    = (st_q == ST_CLS1) || (st_q == ST_CLS2);
  assign mark_req   = (st_q == ST_MARK1) || (st_q == ST_MARK2);
  assign port_on    = (st_q == ST_ON);
  assign det_status = det_q;
  assign cls_status = cls_q;
  assign fault_evt  = flt_q;
endmodule

// File: rtl/pse_port_seq_chk.sv
module pse_port_seq_chk #(
  parameter int CUR_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       mode,
  input logic             fault,
  input logic             det_req,
  input logic             cls_req,
  input logic             mark_req,
  input logic             port_on,
  input logic [2:0]       det_status,
  input logic             fault_evt,
  input logic [CUR_W-1:0] cur_rd
);
  a_r11_shut_drops: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b00) |=> (!port_on && det_status == 3'b000));

  a_r9_fault_off: assert property (@(posedge clk) disable iff (rst)
    (port_on && fault) |=> (!port_on && fault_evt));

  a_r9_fault_sticky: assert property (@(posedge clk) disable iff (rst)
    fault_evt |=> fault_evt);

  a_r10_cur_zero: assert property (@(posedge clk) disable iff (rst)
    !port_on |=> (cur_rd == '0));

  a_r5_one_phase: assert property (@(posedge clk) disable iff (rst)
    $onehot0({det_req, cls_req, mark_req, port_on}));

  a_r4_on_after_good: assert property (@(posedge clk) disable iff (rst)
    ($rose(port_on) && $past(mode) != 2'b01) |-> (det_status == 3'b100));
endmodule

bind pse_port_seq pse_port_seq_chk #(.CUR_W(CUR_W)) u_chk (
  .clk(clk), .rst(rst), .mode(mode), .fault(fault),
  .det_req(det_req), .cls_req(cls_req), .mark_req(mark_req),
  .port_on(port_on), .det_status(det_status), .fault_evt(fault_evt),
  .cur_rd(cur_rd)
);

// File: tb/pse_port_seq_tb.sv
module pse_port_seq_tb_top;
  localparam int         GAP   = 6;
  localparam int         CW    = 10;
  localparam logic [1:0] PID   = 2'd1;
  localparam logic [7:0] ON_B  = 8'h05;
  localparam logic [7:0] OFF_B = 8'h09;

  logic clk = 1'b0, rst = 1'b1;
  logic [1:0] mode = 2'b00;
  logic plus_en = 1'b0, det_done = 1'b0, cls_done = 1'b0, mark_done = 1'b0;
  logic [2:0] det_code = '0, cls_code = '0;
  logic cmd_valid = 1'b0, fault = 1'b0;
  logic [7:0] cmd_byte = '0;
  logic [CW-1:0] cur_in = '0;
  logic det_req, cls_req, mark_req, port_on, fault_evt;
  logic [2:0] det_status, cls_status;
  logic [CW-1:0] cur_rd;

  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  pse_port_seq #(.DET_GAP(GAP), .CUR_W(CW), .PORT_ID(PID)) dut_i (
    .clk(clk), .rst(rst), .mode(mode), .plus_en(plus_en),
    .det_done(det_done), .det_code(det_code), .cls_done(cls_done),
    .cls_code(cls_code), .mark_done(mark_done), .cmd_valid(cmd_valid),
    .cmd_byte(cmd_byte), .fault(fault), .cur_in(cur_in),
    .det_req(det_req), .cls_req(cls_req), .mark_req(mark_req),
    .port_on(port_on), .det_status(det_status), .cls_status(cls_status),
    .fault_evt(fault_evt), .cur_rd(cur_rd)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // kind: 0 detect, 1 class, 2 mark; returns falling edges waited
  task automatic wait_req(input int kind, output int n);
    n = 0;
    while (n < 200 && !((kind == 0 && det_req) || (kind == 1 && cls_req) ||
                        (kind == 2 && mark_req))) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic give_det(input logic [2:0] c);
    int n;
    wait_req(0, n);
    det_done = 1'b1; det_code = c;
    @(negedge clk);
    det_done = 1'b0;
  endtask

  task automatic give_cls(input logic [2:0] c);
    int n;
    wait_req(1, n);
    cls_done = 1'b1; cls_code = c;
    @(negedge clk);
    cls_done = 1'b0;
  endtask

  task automatic give_mark();
    int n;
    wait_req(2, n);
    mark_done = 1'b1;
    @(negedge clk);
    mark_done = 1'b0;
  endtask

  task automatic send_cmd(input logic [7:0] b);
    cmd_valid = 1'b1; cmd_byte = b;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic restart(input logic [1:0] m);
    mode = 2'b00;
    @(negedge clk);
    mode = m;
  endtask

  initial begin
    int n;
    bit seen;
    tick(4);
    rst = 1'b0;
    tick(1);
    // R1 reset state
    chk(!port_on && det_status == 0 && cls_status == 0 && !fault_evt &&
        !det_req && !cls_req && !mark_req, "R1 reset", port_on, 0);

    // R2 shutdown: no probes, power-on ignored
    seen = 1'b0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (det_req) seen = 1'b1; end
    chk(!seen, "R2 no probe", seen, 0);
    send_cmd(ON_B);
    tick(1);
    chk(!port_on, "R2 on ignored", port_on, 0);

    // R3 sweep of non-good detect codes in auto
    mode = 2'b11;
    for (int c = 0; c < 8; c++) begin
      if (c != 4) begin
        give_det(3'(c));
        chk(det_status == 3'(c) && !port_on, "R3 status", det_status, c);
        wait_req(0, n);
        chk(n == GAP, "R3 gap", n, GAP);
      end
    end
    give_det(3'b100);
    chk(det_status == 3'b100 && cls_req, "R4 good to class", det_status, 4);

    // R4 single event power-on
    give_cls(3'b010);
    chk(port_on && cls_status == 3'b010 && !mark_req, "R4 on", port_on, 1);

    // R10 current readback
    cur_in = 10'd321;
    tick(1);
    chk(cur_rd == 10'd321, "R10 on readback", cur_rd, 321);

    // R9 fault
    fault = 1'b1;
    @(negedge clk);
    fault = 1'b0;
    chk(!port_on && fault_evt, "R9 fault off", port_on, 0);
    wait_req(0, n);
    chk(n == GAP, "R9 redetect gap", n, GAP);
    chk(cur_rd == 0, "R10 off zero", cur_rd, 0);

    // R5 sweep of first class code, high-power enabled
    plus_en = 1'b1;
    for (int c = 0; c < 8; c++) begin
      restart(2'b11);
      give_det(3'b100);
      give_cls(3'(c));
      if (c == 4) begin
        chk(mark_req && !port_on, "R5 mark after class4", mark_req, 1);
        give_mark();
        chk(cls_req && !port_on, "R5 second event", cls_req, 1);
        give_cls(3'b100);
        chk(mark_req && !port_on, "R5 second mark", mark_req, 1);
        give_mark();
        chk(port_on, "R6 on after two class4", port_on, 1);
      end else begin
        chk(port_on && !mark_req, "R5 single event", port_on, 1);
      end
    end

    // R6 sweep of second class code
    for (int c = 0; c < 8; c++) begin
      if (c != 4) begin
        restart(2'b11);
        give_det(3'b100);
        give_cls(3'b100);
        give_mark();
        give_cls(3'(c));
        give_mark();
        chk(!port_on && cls_status == 3'(c), "R6 stays off", port_on, 0);
        wait_req(0, n);
        chk(n == GAP, "R6 redetect gap", n, GAP);
      end
    end

    // R7 semi-auto
    restart(2'b10);
    give_det(3'b100);
    give_cls(3'b100);
    chk(!mark_req && !port_on, "R7 no second event", mark_req, 0);
    tick(5);
    chk(!port_on, "R7 waits for host", port_on, 0);
    send_cmd(8'h06);
    tick(1);
    chk(!port_on, "R7 other port ignored", port_on, 0);
    send_cmd(ON_B);
    chk(port_on, "R7 host on", port_on, 1);

    // R8 power-off command
    send_cmd(OFF_B);
    chk(!port_on, "R8 host off", port_on, 0);

    // R8 manual
    restart(2'b01);
    seen = 1'b0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (det_req) seen = 1'b1; end
    chk(!seen, "R8 manual no probe", seen, 0);
    send_cmd(ON_B);
    chk(port_on, "R8 manual on", port_on, 1);
    fault = 1'b1;
    @(negedge clk);
    fault = 1'b0;
    chk(!port_on, "R9 manual fault off", port_on, 0);
    seen = 1'b0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (det_req) seen = 1'b1; end
    chk(!seen, "R9 manual stays idle", seen, 0);

    // R11 shutdown while powered
    send_cmd(ON_B);
    chk(port_on, "R11 precondition", port_on, 1);
    mode = 2'b00;
    @(negedge clk);
    chk(!port_on && det_status == 0 && cls_status == 0, "R11 shutdown", port_on, 0);
    chk(fault_evt, "R9 fault sticky", fault_evt, 1);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule